// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Unit

This unit builds the second operand of an integer ALU together with the carry that the shifter produces. It has two operand sources. In immediate mode an 8-bit constant is rotated right by an even amount. In register mode a 32-bit register value is shifted by an amount that comes either from a 5-bit instruction field or from the low byte of a register. Along with the operand it reports whether a shift or rotation actually took effect. When nothing took effect, the incoming carry flag passes through unchanged.

The result is registered, so it appears one clock after the inputs are presented. Instruction decode and the ALU are not part of this block. The instruction stage drives the field values straight into the ports.

Top module: `op2_shifter`

## Requirements
- R1: With `use_imm`=1, `operand` is the 8-bit `imm_val`, zero-extended to 32 bits and rotated right by 2×`imm_rot` bit positions.
- R2: With `use_imm`=1 and `imm_rot`≠0, `carry_out` equals bit 31 of `operand` and `shifted`=1. With `imm_rot`=0, `carry_out` equals `carry_in` and `shifted`=0.
- R3: `shift_kind` selects the operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For amounts 1 to 31, `operand` is the shifted `reg_val` and `carry_out` is the last bit shifted out (for a rotate, that is bit 31 of the result).
- R4: With `amt_from_reg`=0 and `amt_imm`=0, logical left passes `reg_val` and `carry_in` through unchanged. Logical right and arithmetic right behave as shifts by 32.
- R5: With `amt_from_reg`=0, `amt_imm`=0 and kind 11, the unit performs a one-place rotate through the carry. `operand` = {`carry_in`, `reg_val`[31:1]} and `carry_out` = `reg_val`[0].
- R6: With `amt_from_reg`=1, only `amt_reg`[7:0] is used as the amount. A value of 0 in that byte passes `reg_val` and `carry_in` through unchanged, with `shifted`=0.
- R7: A logical shift by exactly 32 gives zero, with carry = bit 0 for left and bit 31 for right. A logical shift by more than 32 gives zero with carry 0.
- R8: An arithmetic right shift by 32 or more fills every bit with `reg_val`[31`]`, and the carry equals `reg_val`[31].
- R9: A register-specified rotate by a nonzero multiple of 32 returns `reg_val` unchanged, with carry = `reg_val`[31].
- R10: `shifted` is 1 exactly when `carry_out` comes from the shift or rotate logic rather than from `carry_in`.
- R11: Outputs follow their inputs one clock later. While `rst_n` is low, `operand`, `carry_out` and `shifted` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_imm | input | 1 | 1 selects the rotated-immediate source |
| imm_val | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotation; the rotation is twice this value |
| reg_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_reg`, 0 from `amt_imm` |
| amt_imm | input | 5 | Field-specified shift amount |
| amt_reg | input | 32 | Register-specified amount; only bits 7:0 are used |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |
| shifted | output | 1 | Registered flag: shift or rotation took effect |

## Verification
The assertions assume that every input is a known value and holds steady across the clock edge it is sampled on. Their `$past` terms rely on the inputs having been defined in the previous cycle. They also assume the 32-bit width fits within the 8-bit amount field, so that the comparisons against 32 are meaningful. The bench changes inputs only on falling edges, drives only defined values, and holds each case for a full cycle before reading the registered result on the following falling edge.

// File: rtl/op2_pkg.sv
package op2_pkg;
    localparam int unsigned OP_W = 32;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [OP_W-1:0] operand;
        logic            carry;
        logic            shifted;
    } op2_out_t;
endpackage

// File: rtl/op2_rotr.sv
module op2_rotr #(
    parameter int unsigned W  = 32,
    parameter int unsigned SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl  = {din, din} >> amt;
        dout = dbl[W-1:0];
    end
endmodule

// File: rtl/op2_amt_norm.sv
module op2_amt_norm
    import op2_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SH_W   = 5,
    parameter int unsigned AMT_W  = 8,
    parameter int unsigned EA_W   = 9
) (
    input  shift_kind_e       kind,
    input  logic              from_reg,
    input  logic [SH_W-1:0]   amt_field,
    input  logic [AMT_W-1:0]  amt_byte,
    output logic [EA_W-1:0]   eff_amt,
    output logic              is_rrx,
    output logic              is_pass
);
    localparam logic [EA_W-1:0] FULL_AMT = EA_W'(DATA_W);

    always_comb begin
        eff_amt = '0;
        is_rrx  = 1'b0;
        is_pass = 1'b0;
        if (from_reg) begin
            eff_amt = EA_W'(amt_byte);
            is_pass = (amt_byte == '0);
        end else if (amt_field == '0) begin
            unique case (kind)
                SK_LSL: is_pass = 1'b1;
                SK_LSR,
                SK_ASR: eff_amt = FULL_AMT;
                SK_ROR: begin
                    is_rrx  = 1'b1;
                    eff_amt = EA_W'(1);
                end
                default: is_pass = 1'b1;
            endcase
        end else begin
            eff_amt = EA_W'(amt_field);
        end
    end
endmodule

// File: rtl/op2_reg_shift.sv
module op2_reg_shift
    import op2_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter int unsigned SH_W = 5,
    parameter int unsigned EA_W = 9
) (
    input  logic [W-1:0]    value,
    input  shift_kind_e     kind,
    input  logic [EA_W-1:0] eff_amt,
    input  logic            is_rrx,
    input  logic            is_pass,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout,
    output logic            applied
);
    localparam logic [EA_W-1:0] FULL_AMT = EA_W'(W);

    logic [W:0]        left_w;
    logic [W:0]        right_w;
    logic [W:0]        asr_w;
    logic [EA_W-1:0]   asr_amt;
    logic [W-1:0]      rot_res;

    op2_rotr #(.W(W), .SW(SH_W)) u_rot (
        .din  (value),
        .amt  (eff_amt[SH_W-1:0]),
        .dout (rot_res)
    );

    always_comb begin
        left_w  = {1'b0, value} << eff_amt;
        right_w = {value, 1'b0} >> eff_amt;
        asr_amt = (eff_amt > FULL_AMT) ? FULL_AMT : eff_amt;
        asr_w   = $signed({value, 1'b0}) >>> asr_amt;
    end

    always_comb begin
        res     = value;
        cout    = cin;
        applied = 1'b0;
        if (is_rrx) begin
            res     = {cin, value[W-1:1]};
            cout    = value[0];
            applied = 1'b1;
        end else if (!is_pass) begin
            applied = 1'b1;
            unique case (kind)
                SK_LSL: begin
                    res  = left_w[W-1:0];
                    cout = left_w[W];
                end
                SK_LSR: begin
                    res  = right_w[W:1];
                    cout = right_w[0];
                end
                SK_ASR: begin
                    res  = asr_w[W:1];
                    cout = asr_w[0];
                end
                SK_ROR: begin
                    res  = rot_res;
                    cout = rot_res[W-1];
                end
                default: begin
                    res  = value;
                    cout = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
    import op2_pkg::*;
#(
    parameter int unsigned DATA_W = op2_pkg::OP_W,
    parameter int unsigned IMM_W  = 8,
    parameter int unsigned ROT_W  = 4,
    parameter int unsigned AMT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       use_imm,
    input  logic [IMM_W-1:0]           imm_val,
    input  logic [ROT_W-1:0]           imm_rot,
    input  logic [DATA_W-1:0]          reg_val,
    input  logic [1:0]                 shift_kind,
    input  logic                       amt_from_reg,
    input  logic [$clog2(DATA_W)-1:0]  amt_imm,
    input  logic [DATA_W-1:0]          amt_reg,
    input  logic                       carry_in,
    output logic [DATA_W-1:0]          operand,
    output logic                       carry_out,
    output logic                       shifted
);
    localparam int unsigned SH_W = $clog2(DATA_W);
    localparam int unsigned EA_W = AMT_W + 1;

    shift_kind_e        kind;
    logic [DATA_W-1:0]  imm_ext;
    logic [SH_W-1:0]    imm_amt;
    logic [DATA_W-1:0]  imm_res;
    logic [EA_W-1:0]    eff_amt;
    logic               is_rrx;
    logic               is_pass;
    logic [DATA_W-1:0]  sh_res;
    logic               sh_cout;
    logic               sh_applied;
    op2_out_t           out_d;
    op2_out_t           out_q;

    assign kind    = shift_kind_e'(shift_kind);
    assign imm_ext = DATA_W'(imm_val);
    assign imm_amt = SH_W'({imm_rot, 1'b0});

    op2_rotr #(.W(DATA_W), .SW(SH_W)) u_imm_rot (
        .din  (imm_ext),
        .amt  (imm_amt),
        .dout (imm_res)
    );

    op2_amt_norm #(.DATA_W(DATA_W), .SH_W(SH_W), .AMT_W(AMT_W), .EA_W(EA_W)) u_norm (
        .kind      (kind),
        .from_reg  (amt_from_reg),
        .amt_field (amt_imm),
        .amt_byte  (amt_reg[AMT_W-1:0]),
        .eff_amt   (eff_amt),
        .is_rrx    (is_rrx),
        .is_pass   (is_pass)
    );

    op2_reg_shift #(.W(DATA_W), .SH_W(SH_W), .EA_W(EA_W)) u_shift (
        .value   (reg_val),
        .kind    (kind),
        .eff_amt (eff_amt),
        .is_rrx  (is_rrx),
        .is_pass (is_pass),
        .cin     (carry_in),
        .res     (sh_res),
        .cout    (sh_cout),
        .applied (sh_applied)
    );

    always_comb begin
        out_d = '0;
        if (use_imm) begin
            out_d.operand = imm_res;
            out_d.shifted = (imm_rot != '0);
            out_d.carry   = out_d.shifted ? imm_res[DATA_W-1] : carry_in;
        end else begin
            out_d.operand = sh_res;
            out_d.carry   = sh_cout;
            out_d.shifted = sh_applied;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign operand   = out_q.operand;
    assign carry_out = out_q.carry;
    assign shifted   = out_q.shifted;

    AST_IMM_ROT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && imm_rot != '0) |=> (carry_out == operand[DATA_W-1]) && shifted); // R2

    AST_IMM_NO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && imm_rot == '0) |=>
            (operand == DATA_W'($past(imm_val))) && (carry_out == $past(carry_in)) && !shifted); // R2

    AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && amt_from_reg && amt_reg[AMT_W-1:0] == '0) |=>
            (operand == $past(reg_val)) && (carry_out == $past(carry_in)) && !shifted); // R6

    AST_RRX_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && !amt_from_reg && shift_kind == 2'b11 && amt_imm == '0) |=>
            (operand[DATA_W-1] == $past(carry_in)) && (carry_out == $past(reg_val[0]))); // R5

    AST_LOGIC_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && amt_from_reg && shift_kind[1] == 1'b0 &&
         amt_reg[AMT_W-1:0] > AMT_W'(DATA_W)) |=> (operand == '0) && !carry_out); // R7

    AST_ASR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_imm && amt_from_reg && shift_kind == 2'b10 &&
         amt_reg[AMT_W-1:0] >= AMT_W'(DATA_W)) |=>
            (operand == {DATA_W{$past(reg_val[DATA_W-1])}}) &&
            (carry_out == $past(reg_val[DATA_W-1]))); // R8
endmodule

// File: tb/sim_op2_shifter.sv
`timescale 1ns/1ps
module sim_op2_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm_val = '0;
    logic [3:0]  imm_rot = '0;
    logic [31:0] reg_val = '0;
    logic [1:0]  shift_kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;
    logic        shifted;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    op2_shifter u0 (
        .clk(clk), .rst_n(rst_n), .use_imm(use_imm), .imm_val(imm_val),
        .imm_rot(imm_rot), .reg_val(reg_val), .shift_kind(shift_kind),
        .amt_from_reg(amt_from_reg), .amt_imm(amt_imm), .amt_reg(amt_reg),
        .carry_in(carry_in), .operand(operand), .carry_out(carry_out),
        .shifted(shifted)
    );

    // Reference built from single-place steps, one bit at a time.
    task automatic model(input logic ui, input logic [7:0] iv, input logic [3:0] ir,
                         input logic [31:0] rv, input logic [1:0] k, input logic fr,
                         input logic [4:0] ai, input logic [31:0] ar, input logic ci,
                         output logic [31:0] e, output logic c, output logic s,
                         output string tag);
        int  n;
        bit  rrx;
        rrx = 1'b0;
        if (ui) begin
            e = {24'b0, iv};
            for (int i = 0; i < 2 * int'(ir); i++) e = {e[0], e[31:1]};
            s = (ir != 0);
            c = s ? e[31] : ci;
            tag = "R1/R2";
            return;
        end
        if (fr) begin
            n = int'(ar[7:0]);
            if (n == 0) tag = "R6";
            else if (k[1] == 1'b0 && n >= 32) tag = "R7";
            else if (k == 2'b10 && n >= 32) tag = "R8";
            else if (k == 2'b11 && n % 32 == 0) tag = "R9";
            else tag = "R3";
        end else if (ai == 0) begin
            tag = "R4";
            if (k == 2'b00) n = 0;
            else if (k == 2'b11) begin rrx = 1'b1; n = 1; tag = "R5"; end
            else n = 32;
        end else begin
            n = int'(ai);
            tag = "R3";
        end
        e = rv; c = ci; s = 1'b0;
        if (rrx) begin
            c = rv[0];
            e = {ci, rv[31:1]};
            s = 1'b1;
        end else if (n != 0) begin
            s = 1'b1;
            for (int i = 0; i < n; i++) begin
                case (k)
                    2'b00: begin c = e[31]; e = {e[30:0], 1'b0}; end
                    2'b01: begin c = e[0];  e = {1'b0, e[31:1]}; end
                    2'b10: begin c = e[0];  e = {e[31], e[31:1]}; end
                    default: begin c = e[0]; e = {e[0], e[31:1]}; end
                endcase
            end
        end
    endtask

    // R11: inputs applied on a falling edge, result read one clock later.
    task automatic run_case(input logic ui, input logic [7:0] iv, input logic [3:0] ir,
                            input logic [31:0] rv, input logic [1:0] k, input logic fr,
                            input logic [4:0] ai, input logic [31:0] ar, input logic ci);
        logic [31:0] e;
        logic        c;
        logic        s;
        string       tag;
        model(ui, iv, ir, rv, k, fr, ai, ar, ci, e, c, s, tag);
        @(negedge clk);
        use_imm = ui; imm_val = iv; imm_rot = ir; reg_val = rv; shift_kind = k;
        amt_from_reg = fr; amt_imm = ai; amt_reg = ar; carry_in = ci;
        @(negedge clk);
        n_tests++;
        if (operand !== e || carry_out !== c || shifted !== s) begin
            n_fail++;
            // shifted mismatch belongs to R10
            $display("FAIL %s R10 R11 k=%0d amt_i=%0d amt_r=%0h rv=%h: got op=%h c=%b s=%b exp op=%h c=%b s=%b",
                     tag, k, ai, ar, rv, operand, carry_out, shifted, e, c, s);
        end
    endtask

    initial begin
        logic [31:0] vals [6];
        logic [31:0] ramts [14];
        logic [7:0]  imms [8];
        vals  = '{32'h8000_0001, 32'hF0F0_1234, 32'h7FFF_FFFE, 32'hA5A5_A5A5,
                  32'h0000_0000, 32'hFFFF_FFFF};
        ramts = '{32'd0, 32'd1, 32'd31, 32'd32, 32'd33, 32'd40, 32'd63, 32'd64,
                  32'd96, 32'd255, 32'h100, 32'h120, 32'hFFFF_FF01, 32'h1FF};
        imms  = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5, 8'h3C, 8'h7F, 8'hC3};

        // R11: reset state
        repeat (3) @(negedge clk);
        n_tests++;
        if (operand !== '0 || carry_out !== 1'b0 || shifted !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: got op=%h c=%b s=%b exp 0 0 0", operand, carry_out, shifted);
        end
        rst_n = 1'b1;

        // R1 R2: every immediate rotation
        foreach (imms[i])
            for (int r = 0; r < 16; r++)
                for (int ci = 0; ci < 2; ci++)
                    run_case(1'b1, imms[i], 4'(r), 32'h1234_5678, 2'b00, 1'b0, 5'd0, 32'd0, 1'(ci));

        // R3 R4 R5: all field amounts for every kind
        foreach (vals[v])
            for (int k = 0; k < 4; k++)
                for (int ci = 0; ci < 2; ci++)
                    for (int a = 0; a < 32; a++)
                        run_case(1'b0, 8'h00, 4'd0, vals[v], 2'(k), 1'b0, 5'(a), 32'hDEAD_BEEF, 1'(ci));

        // R6 R7 R8 R9: register amounts, including upper bits that must be ignored
        foreach (vals[v])
            for (int k = 0; k < 4; k++)
                for (int ci = 0; ci < 2; ci++) begin
                    foreach (ramts[j])
                        run_case(1'b0, 8'h00, 4'd0, vals[v], 2'(k), 1'b1, 5'd7, ramts[j], 1'(ci));
                    for (int a = 2; a < 31; a += 3)
                        run_case(1'b0, 8'h00, 4'd0, vals[v], 2'(k), 1'b1, 5'd0, 32'(a), 1'(ci));
                end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got running exp finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule